// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date in eight packed-BCD bytes: seconds, minutes, hours, date, month, year, weekday and century. An upstream divider supplies a single-cycle pulse once per second. The block moves the time forward on that pulse. It handles both hour formats, months of different lengths, and leap years up to the end of the 2000s.

A host-side buffer writes new values through a byte-masked parallel load port. Any subset of bytes can be written in one cycle. The written bytes replace the live fields on the next seconds pulse, and that pulse does not count the time forward. All eight bytes are always visible on one output bus, so the host can take a snapshot at any time.

After reset the block treats itself as having lost all power. It raises a halt flag and ignores seconds pulses until at least one byte has been loaded.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, every time byte reads 00h except the century byte, which reads 20h. The halt flag reads 1.
- R2: While the halt flag is set, seconds pulses leave every byte unchanged.
- R3: A load with a nonzero byte mask clears the halt flag in the next cycle and leaves the time unchanged until the next seconds pulse. On that pulse, only the masked bytes take the loaded values, and no field advances.
- R4: Seconds (byte 0) and minutes (byte 1) count 00 to 59. Each one wraps to 00 and carries into the next field.
- R5: When bit 7 of the hour byte (byte 2) is 1, the hour uses 24-hour format in bits 5:0. It counts 00 to 23, and passing 23 carries into the day.
- R6: When bit 7 of the hour byte is 0, the hour uses 12-hour format. Bits 4:0 count 12, 01, ..., 11, and bit 5 (1 = PM) toggles on the 11 to 12 step. Only the PM 11 to AM 12 step carries into the day.
- R7: The date (byte 3) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except February. The month is byte 4.
- R8: In February the date wraps after 29 when the year (byte 5) modulo 4 is 0, and after 28 otherwise.
- R9: The weekday (byte 6) advances on every day carry and wraps from 6 to 0.
- R10: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and adds one (BCD) to the century (byte 7).
- R11: A field that holds an illegal BCD digit or a value above its maximum keeps that value until a step reaches it. That step sets the field to its minimum and carries, except in the 12-hour format, where an illegal hour becomes 12 with no carry.
- R12: With no seconds pulse and no pending load, no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset, meaning a total loss of power |
| secTick | input | 1 | One-cycle pulse once per second |
| loadMask | input | 8 | Byte-select mask for a load; bit i selects byte i |
| loadBytes | input | 64 | Values to load; byte i sits in bits 8i+7:8i |
| timeBytes | output | 64 | Live time and date bytes, in the same layout |
| haltFlag | output | 1 | Set from reset until the first load |

## Verification
The assertions assume that `secTick` is a single-cycle pulse synchronous to `clk`. The range assertions also assume that the host loads legal BCD into a field before they rely on that field staying in range, so they apply only to steps that start from a legal value. The stimulus follows these assumptions: every pulse lasts exactly one cycle, and every illegal value is loaded on purpose to exercise R11. The stimulus always lets a staged load take effect on its own pulse before the next load arrives, so a load never coincides with a pulse.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 8;
  localparam int BUS_W     = BYTE_W * NUM_BYTES;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_WDAY = 6;
  localparam int IDX_CENT = 7;

  localparam logic [BYTE_W-1:0] CENT_RESET = 8'h20;

  typedef struct packed {
    logic                 advance;
    logic [NUM_BYTES-1:0] stageWr;
    logic [NUM_BYTES-1:0] applyMask;
  } tkStrobe_t;

  function automatic logic isBad(input logic [7:0] v);
    return (v[3:0] > 4'd9) || (v[7:4] > 4'd9);
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // returns {carry, nextValue}
  function automatic logic [8:0] stepField(input logic [7:0] v,
                                           input logic [7:0] maxV,
                                           input logic [7:0] minV);
    if (isBad(v) || v >= maxV) return {1'b1, minV};
    else                       return {1'b0, bcdInc(v)};
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [7:0] month,
                                             input logic [7:0] year);
    logic [6:0] yearBin;
    yearBin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (month)
      8'h02:                      return (yearBin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic [NUM_BYTES-1:0] loadMask,
  output tkStrobe_t            strb,
  output logic                 haltFlag
);
  logic                 haltQ;
  logic [NUM_BYTES-1:0] pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b1;
      pendQ <= '0;
    end else begin
      if (|loadMask) haltQ <= 1'b0;
      if (secTick) pendQ <= loadMask;
      else         pendQ <= pendQ | loadMask;
    end
  end

  always_comb begin
    strb.stageWr   = loadMask;
    strb.applyMask = secTick ? pendQ : '0;
    strb.advance   = secTick && !haltQ && (pendQ == '0);
  end

  assign haltFlag = haltQ;

  // R2: the halt flag stays set until a load arrives
  p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    haltQ && (loadMask == '0) |=> haltQ);

  // R3: any load releases the halt
  p_load_clears_halt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|loadMask) |=> !haltFlag);

  // R3: a staged load is applied on exactly one pulse
  p_apply_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.applyMask) && (loadMask == '0) |=> (strb.applyMask == '0));
endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tkStrobe_t        strb,
  input  logic [BUS_W-1:0] loadBytes,
  output logic [BUS_W-1:0] timeBytes
);
  logic [BYTE_W-1:0] liveQ  [NUM_BYTES];
  logic [BYTE_W-1:0] stageQ [NUM_BYTES];
  logic [BYTE_W-1:0] advByte[NUM_BYTES];

  logic [8:0] secStep, minStep, hourStep, dateStep, wdayStep, monStep, yearStep, centStep;
  logic       hourCarry;
  logic [7:0] hourNext, dimNow;
  logic [4:0] hour12;
  logic       pmNow;

  always_comb begin
    secStep  = stepField(liveQ[IDX_SEC], 8'h59, 8'h00);
    minStep  = secStep[8] ? stepField(liveQ[IDX_MIN], 8'h59, 8'h00)
                          : {1'b0, liveQ[IDX_MIN]};
    hour12    = liveQ[IDX_HOUR][4:0];
    pmNow     = liveQ[IDX_HOUR][5];
    hourNext  = liveQ[IDX_HOUR];
    hourCarry = 1'b0;
    hourStep  = '0;
    if (minStep[8]) begin
      if (liveQ[IDX_HOUR][7]) begin
        hourStep  = stepField({2'b00, liveQ[IDX_HOUR][5:0]}, 8'h23, 8'h00);
        hourNext  = {2'b10, hourStep[5:0]};
        hourCarry = hourStep[8];
      end else if (isBad({3'b000, hour12}) || hour12 > 5'h12 || hour12 == 5'h00) begin
        hourNext = {2'b00, pmNow, 5'h12};  // R11: illegal 12-hour value
      end else if (hour12 == 5'h11) begin
        hourNext  = {2'b00, ~pmNow, 5'h12};
        hourCarry = pmNow;
      end else if (hour12 == 5'h12) begin
        hourNext = {2'b00, pmNow, 5'h01};
      end else begin
        hourNext = {2'b00, pmNow, bcdInc({3'b000, hour12})[4:0]};
      end
    end
    dimNow   = daysInMonth(liveQ[IDX_MON], liveQ[IDX_YEAR]);
    dateStep = hourCarry ? stepField(liveQ[IDX_DATE], dimNow, 8'h01)
                         : {1'b0, liveQ[IDX_DATE]};
    wdayStep = hourCarry ? stepField(liveQ[IDX_WDAY], 8'h06, 8'h00)
                         : {1'b0, liveQ[IDX_WDAY]};
    monStep  = dateStep[8] ? stepField(liveQ[IDX_MON], 8'h12, 8'h01)
                           : {1'b0, liveQ[IDX_MON]};
    yearStep = monStep[8] ? stepField(liveQ[IDX_YEAR], 8'h99, 8'h00)
                          : {1'b0, liveQ[IDX_YEAR]};
    centStep = yearStep[8] ? stepField(liveQ[IDX_CENT], 8'h99, 8'h00)
                           : {1'b0, liveQ[IDX_CENT]};

    advByte[IDX_SEC]  = secStep[7:0];
    advByte[IDX_MIN]  = minStep[7:0];
    advByte[IDX_HOUR] = hourNext;
    advByte[IDX_DATE] = dateStep[7:0];
    advByte[IDX_MON]  = monStep[7:0];
    advByte[IDX_YEAR] = yearStep[7:0];
    advByte[IDX_WDAY] = wdayStep[7:0];
    advByte[IDX_CENT] = centStep[7:0];
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] RST_VAL = (i == IDX_CENT) ? CENT_RESET : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[i] <= '0;
        liveQ[i]  <= RST_VAL;
      end else begin
        if (strb.stageWr[i]) stageQ[i] <= loadBytes[i*BYTE_W +: BYTE_W];
        if (strb.applyMask[i])  liveQ[i] <= stageQ[i];
        else if (strb.advance)  liveQ[i] <= advByte[i];
      end
    end

    assign timeBytes[i*BYTE_W +: BYTE_W] = liveQ[i];
  end

  // R12: with no strobes the time holds
  p_quiet_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance && (strb.applyMask == '0) |=> $stable(timeBytes));

  // R3: an applying pulse leaves unmasked seconds alone
  p_apply_unmasked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.applyMask) && !strb.applyMask[IDX_SEC] |=> $stable(liveQ[IDX_SEC]));

  // R4: seconds stay within 00..59 once legal
  p_sec_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !isBad(liveQ[IDX_SEC]) && liveQ[IDX_SEC] <= 8'h59
    |=> !isBad(liveQ[IDX_SEC]) && liveQ[IDX_SEC] <= 8'h59);

  // R6: AM/PM flips on the 11 to 12 step
  p_pm_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && liveQ[IDX_SEC] == 8'h59 && liveQ[IDX_MIN] == 8'h59 &&
    liveQ[IDX_HOUR][7:6] == 2'b00 && liveQ[IDX_HOUR][4:0] == 5'h11
    |=> liveQ[IDX_HOUR][5] != $past(liveQ[IDX_HOUR][5]));

  // R9: weekday stays within 0..6 once legal
  p_wday_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && liveQ[IDX_WDAY] <= 8'h06 |=> liveQ[IDX_WDAY] <= 8'h06);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import tk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic [NUM_BYTES-1:0] loadMask,
  input  logic [BUS_W-1:0]     loadBytes,
  output logic [BUS_W-1:0]     timeBytes,
  output logic                 haltFlag
);
  tkStrobe_t strb;

  tk_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .loadMask (loadMask),
    .strb     (strb),
    .haltFlag (haltFlag)
  );

  tk_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadBytes (loadBytes),
    .timeBytes (timeBytes)
  );
endmodule

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic [7:0]  loadMask = '0;
  logic [63:0] loadBytes = '0;
  logic [63:0] timeBytes;
  logic        haltFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcd_calendar i_bcd_calendar (
    .clk(clk), .rstN(rstN), .secTick(secTick), .loadMask(loadMask),
    .loadBytes(loadBytes), .timeBytes(timeBytes), .haltFlag(haltFlag)
  );

  // {req, start, expected after one step}; bytes: cent,wday,year,mon,date,hour,min,sec
  localparam int NV = 16;
  localparam logic [135:0] VEC [NV] = '{
    {8'd4,  64'h20032405_15902207, 64'h20032405_15902208},  // R4 plain second
    {8'd4,  64'h20032405_15902259, 64'h20032405_15902300},  // R4 minute carry
    {8'd5,  64'h20032405_15A35959, 64'h20042405_16800000},  // R5 24h day carry
    {8'd7,  64'h20022404_30A35959, 64'h20032405_01800000},  // R7 30-day month
    {8'd7,  64'h20022401_30A35959, 64'h20032401_31800000},  // R7 31-day month
    {8'd8,  64'h20062402_28A35959, 64'h20002402_29800000},  // R8 leap Feb 28, R9 wrap
    {8'd8,  64'h20012302_28A35959, 64'h20022303_01800000},  // R8 common Feb 28
    {8'd8,  64'h20002402_29A35959, 64'h20012403_01800000},  // R8 leap Feb 29
    {8'd10, 64'h20059912_31A35959, 64'h21060001_01800000},  // R10 year 99 wrap
    {8'd10, 64'h20032312_31A35959, 64'h20042401_01800000},  // R10 month wrap
    {8'd10, 64'h19039912_31A35959, 64'h20040001_01800000},  // R10 century 19 to 20
    {8'd6,  64'h20032405_15115959, 64'h20032405_15320000},  // R6 AM 11 to PM 12
    {8'd6,  64'h20032405_15325959, 64'h20032405_15210000},  // R6 PM 12 to 1
    {8'd6,  64'h20032405_15315959, 64'h20042405_16120000},  // R6 PM 11 to AM 12 carry
    {8'd11, 64'h20032405_1590225A, 64'h20032405_15902300},  // R11 bad second
    {8'd11, 64'h20032405_3FA35959, 64'h20042406_01800000}   // R11 bad date
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic doLoad(input logic [7:0] m, input logic [63:0] b);
    @(negedge clk); loadMask = m; loadBytes = b;
    @(negedge clk); loadMask = '0;
  endtask

  task automatic doTick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", timeBytes, 64'h20000000_00000000);
    check("R1", {63'd0, haltFlag}, 64'd1);

    doTick(); doTick();
    check("R2", timeBytes, 64'h20000000_00000000);
    check("R2", {63'd0, haltFlag}, 64'd1);

    doLoad(8'h01, 64'h00000000_00000045);
    check("R3", {63'd0, haltFlag}, 64'd0);
    check("R3", timeBytes, 64'h20000000_00000000);
    doTick();
    check("R3", timeBytes, 64'h20000000_00000045);
    doTick();
    check("R4", timeBytes, 64'h20000000_00000046);
    repeat (4) @(negedge clk);
    check("R12", timeBytes, 64'h20000000_00000046);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][135:128]);
      doLoad(8'hFF, VEC[v][127:64]);
      doTick();
      check("R3", timeBytes, VEC[v][127:64]);
      doTick();
      check(tag, timeBytes, VEC[v][63:0]);
    end

    // R11: illegal minute held while seconds count
    doLoad(8'hFF, 64'h20032405_15907B10);
    doTick(); doTick();
    check("R11", timeBytes, 64'h20032405_15907B11);

    // R3: single-byte load while running, no advance on the applying pulse
    snap = timeBytes;
    doLoad(8'h02, 64'h00000000_00001000);
    doTick();
    check("R3", timeBytes, {snap[63:16], 8'h10, snap[7:0]});
    doTick();
    check("R4", timeBytes, {snap[63:16], 8'h10, snap[7:0] + 8'h01});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule